// File: doc/BRIEF.md
# Byte-Sliced Dual-Rail Completion Detector

This block tells the control logic when a wide dual-rail datapath has finished a phase. Each bit arrives on a pair of rails. A bit with exactly one rail high carries a value. A bit with both rails low is neutral. The block watches every bit and raises a "done" indication once the whole group carries values. It drops that indication once the whole group is neutral again. For any mix of valid and neutral bits it keeps its previous value. This hysteresis is what a four-phase handshake needs from a completion signal.

The word is cut into slices of `SLICE_W` bits, 8 by default. Each slice runs its own tree of two-input Muller C-elements, and all the slice trees work in parallel. A second C-element tree merges the slice outputs into a word-level done. Each C-element is modelled as a clocked hold-state register, so each tree level costs one clock. A slice therefore reports log2(`SLICE_W`) clocks after its inputs settle, and the word output comes log2(`W`/`SLICE_W`) clocks after that. Both `SLICE_W` and `W`/`SLICE_W` are assumed to be powers of two.

Top module: `completion_detect`

## Requirements
- R1: A bit counts as valid when either rail is high. Rail pairs (true,false) = (1,0) and (0,1) both count as valid. The pair (0,0) is neutral.
- R2: A slice's done output goes from 0 to 1 only after every bit of that slice has been valid.
- R3: A slice's done output goes from 1 to 0 only after every bit of that slice has been neutral.
- R4: While a slice holds a mix of valid and neutral bits, its done output keeps its previous value.
- R5: Once a slice's inputs are stable, its done output changes exactly log2(`SLICE_W`) clock edges later. For `SLICE_W`=8 this is 3 edges.
- R6: The word done output is a C-element merge of all slice outputs. It rises when all slice outputs are 1, falls when all are 0, and otherwise holds. It lags the slice outputs by log2(`W`/`SLICE_W`) edges.
- R7: The synchronous active-low reset clears every C-element, so all done outputs read 0 during and right after reset, whatever the rails carry.
- R8: A slice's done output depends only on the bits of its own slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples every C-element |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_t | input | W | True rail of each bit |
| rail_f | input | W | False rail of each bit |
| slice_done | output | W/SLICE_W | Completion of each slice; bit s covers bits s*SLICE_W upward |
| word_done | output | 1 | Completion of the whole word |

## Verification
The bench builds the block with `W`=16 and `SLICE_W`=8. This gives two full-size 8-input slice trees of depth three and a one-level word merge. Every one of the 256 validity masks of slice 0 is swept, each paired with slice 1 all neutral, all valid, or a second mask. Each combination is entered both from the all-neutral state and from the all-valid state, so every rise, fall and hold case of both slices and of the word output is visited. The rail used by each valid bit also varies. Separate checks count the exact edges from a settled input to each output.

// File: rtl/cdt_pkg.sv
// Package: shared helpers for the completion detector.
// Assumes rails are sampled at the block's clock.
package cdt_pkg;

    // Validity of one dual-rail bit: either rail high.
    function automatic logic dr_valid(input logic t, input logic f);
        return t | f;
    endfunction

    // True when n is a nonzero power of two.
    function automatic bit is_pow2(input int n);
        return (n > 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/celem2.sv
// Module: two-input Muller C-element modelled as a clocked hold register.
// Output takes the common input value when both inputs agree, else holds.
// Assumes synchronous active-low reset to 0.
module celem2 (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q
);

    // Hold-state update: follow agreed inputs, keep value otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (a == b)
            q <= a;
    end

    assert_rise_only_all_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> ($past(a) && $past(b)));

    assert_fall_only_all_neutral_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> (!$past(a) && !$past(b)));

    assert_mixed_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a != b) |=> $stable(q));

    assert_agree_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a == b) |=> (q == $past(a)));

endmodule

// File: rtl/cel_tree.sv
// Module: balanced tree of two-input C-elements over N leaves.
// Heap layout: node k merges nodes 2k and 2k+1; leaves sit at N..2N-1.
// Assumes N is a power of two; latency is log2(N) clocks (0 for N=1).
module cel_tree #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] leaf,
    output logic         root
);

    generate
        if (N == 1) begin : g_pass
            // Single leaf: nothing to merge.
            assign root = leaf[0];
        end else begin : g_tree
            logic [2*N-1:1] node;

            // Leaves feed the bottom row of the heap.
            assign node[2*N-1:N] = leaf;

            for (genvar k = 1; k < N; k++) begin : g_node
                celem2 u_ce (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .a    (node[2*k]),
                    .b    (node[2*k+1]),
                    .q    (node[k])
                );
            end

            assign root = node[1];
        end
    endgenerate

endmodule

// File: rtl/cd_slice.sv
// Module: one slice of the completion detector.
// Derives per-bit validity from the rail pairs and reduces it through a
// C-element tree. Assumes SLICE_W is a power of two.
module cd_slice #(
    parameter int SLICE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLICE_W-1:0] rt,
    input  logic [SLICE_W-1:0] rf,
    output logic               done
);
    import cdt_pkg::*;

    logic [SLICE_W-1:0] bit_ok;

    // Per-bit validity detector, one OR per bit.
    for (genvar i = 0; i < SLICE_W; i++) begin : g_bit
        assign bit_ok[i] = dr_valid(rt[i], rf[i]);
    end

    cel_tree #(.N(SLICE_W)) u_tree (
        .clk  (clk),
        .rst_n(rst_n),
        .leaf (bit_ok),
        .root (done)
    );

endmodule

// File: rtl/completion_detect.sv
// Module: top of the byte-sliced completion detector.
// Splits W dual-rail bits into W/SLICE_W slices that run in parallel, then
// merges the slice outputs with a second C-element tree.
// Assumes W is a multiple of SLICE_W and both SLICE_W and W/SLICE_W are
// powers of two.
module completion_detect #(
    parameter int W       = 32,
    parameter int SLICE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [W-1:0]           rail_t,
    input  logic [W-1:0]           rail_f,
    output logic [W/SLICE_W-1:0]   slice_done,
    output logic                   word_done
);
    import cdt_pkg::*;

    localparam int NSLICE = W / SLICE_W;

    // Elaboration-time shape check.
    initial begin
        assert_shape_R6: assert (is_pow2(SLICE_W) && is_pow2(NSLICE) && (NSLICE * SLICE_W == W))
            else $error("completion_detect: unsupported W/SLICE_W");
    end

    // Parallel slice trees.
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        cd_slice #(.SLICE_W(SLICE_W)) u_slice (
            .clk  (clk),
            .rst_n(rst_n),
            .rt   (rail_t[s*SLICE_W +: SLICE_W]),
            .rf   (rail_f[s*SLICE_W +: SLICE_W]),
            .done (slice_done[s])
        );
    end

    // Word-level merge of the slice outputs.
    cel_tree #(.N(NSLICE)) u_merge (
        .clk  (clk),
        .rst_n(rst_n),
        .leaf (slice_done),
        .root (word_done)
    );

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (word_done == 1'b0 && slice_done == '0));

endmodule

// File: tb/completion_detect_bench.sv
// Bench: sweeps slice-0 validity masks against slice-1 patterns in both
// directions, plus reset and latency checks. W=16, SLICE_W=8.
module completion_detect_bench;

    localparam int W       = 16;
    localparam int SLICE_W = 8;
    localparam int NSLICE  = W / SLICE_W;
    localparam int SETTLE  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [W-1:0]      rail_t = '0;
    logic [W-1:0]      rail_f = '0;
    logic [NSLICE-1:0] slice_done;
    logic              word_done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    completion_detect #(.W(W), .SLICE_W(SLICE_W)) u_completion_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .rail_t    (rail_t),
        .rail_f    (rail_f),
        .slice_done(slice_done),
        .word_done (word_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive a validity mask; data picks which rail each valid bit uses.
    task automatic drive(input logic [W-1:0] mask, input logic [W-1:0] data);
        @(negedge clk);
        rail_t = mask & data;
        rail_f = mask & ~data;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R7: reset holds outputs low even with all bits valid.
        rail_t = 16'hA5A5;
        rail_f = 16'h5A5A;
        repeat (4) @(negedge clk);
        chk("R7 slice_done in reset", slice_done, 0);
        chk("R7 word_done in reset", word_done, 0);
        drive('0, '0);
        rst_n = 1'b1;
        settle();
        chk("R7 slice_done after reset", slice_done, 0);
        chk("R7 word_done after reset", word_done, 0);

        // R5/R6 latency, rising: 3 edges for slice, 4 for word.
        drive(16'hFFFF, 16'h0F33);
        @(negedge clk); @(negedge clk);
        chk("R5 slice not yet after 2 edges", slice_done, 0);
        @(negedge clk);
        chk("R5 slice done after 3 edges", slice_done, 2'b11);
        chk("R6 word not yet after 3 edges", word_done, 0);
        @(negedge clk);
        chk("R6 word done after 4 edges", word_done, 1);
        // Falling latency.
        drive(16'h0000, 16'h0000);
        @(negedge clk); @(negedge clk);
        chk("R5 slice still high after 2 edges", slice_done, 2'b11);
        @(negedge clk);
        chk("R5 slice low after 3 edges", slice_done, 0);
        chk("R6 word still high after 3 edges", word_done, 1);
        @(negedge clk);
        chk("R6 word low after 4 edges", word_done, 0);

        // Sweep: all slice-0 masks, three slice-1 patterns, both directions.
        for (int m = 0; m < 256; m++) begin
            for (int p = 0; p < 3; p++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    logic [7:0]   m0;
                    logic [7:0]   m1;
                    logic [W-1:0] mask;
                    logic [W-1:0] data;
                    logic         e0;
                    logic         e1;
                    logic         ew;
                    m0 = 8'(m);
                    m1 = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'(m * 37 + 11);
                    mask = {m1, m0};
                    data = 16'(m * 16'h9E37) ^ 16'(p * 16'h1357);
                    // Known start state: all neutral (dir 0) or all valid (dir 1).
                    if (dir == 0) drive('0, '0);
                    else          drive('1, ~data);
                    settle();
                    drive(mask, data);
                    settle();
                    if (dir == 0) begin
                        // R2: rise only if all valid; R4 mixed holds 0.
                        e0 = (m0 == 8'hFF);
                        e1 = (m1 == 8'hFF);
                        ew = e0 && e1;
                        chk("R2 slice0 from neutral", slice_done[0], e0);
                        chk("R8 slice1 from neutral", slice_done[1], e1);
                        chk("R6 word from neutral", word_done, ew);
                    end else begin
                        // R3: fall only if all neutral; R4 mixed holds 1.
                        e0 = (m0 != 8'h00);
                        e1 = (m1 != 8'h00);
                        ew = e0 || e1;
                        chk("R3 slice0 from valid", slice_done[0], e0);
                        chk("R4 slice1 from valid", slice_done[1], e1);
                        chk("R6 word from valid", word_done, ew);
                    end
                end
            end
        end

        // R1: each valid code alone completes a slice.
        drive('0, '0); settle();
        drive(16'hFFFF, 16'hFFFF); settle();
        chk("R1 true rail only", slice_done, 2'b11);
        drive('0, '0); settle();
        drive(16'hFFFF, 16'h0000); settle();
        chk("R1 false rail only", slice_done, 2'b11);
        chk("R1 word with false rail", word_done, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule